// File: doc/BRIEF.md
# Translation Lookaside Buffer with Usage Bits

A small, fully associative store of page table entries placed between the address generator and memory. A lookup presents a virtual page number together with a read/write flag. A hit returns the physical page number combinationally in the same cycle. A miss is flagged in that same cycle, so the requester can stall, fetch the entry from the page table and then present it on the fill port. The lookup is then retried.

Each entry keeps a reference bit and a dirty bit. A hit sets the reference bit, and a write hit also sets the dirty bit. A bulk clear drops all reference bits, so software can age the entries. Replacement approximates least-recently-used order through a rotating pointer. When a victim that was referenced or written is displaced, its virtual page number and status bits are reported on an eviction port for one cycle, so they can be written back to the page table.

Top module: `xlat_buf`

## Requirements
- R1: The buffer holds N_ENTRIES entries (parameter, 16 to 512, default 16), and any entry may hold any virtual page number. With lkp_valid_i high and a valid entry matching lkp_vpn_i, hit_o is 1 and ppn_o carries that entry's physical page number in the same cycle. Otherwise ppn_o is 0.
- R2: With lkp_valid_i high and no valid match, miss_o is 1 in the same cycle. With lkp_valid_i low, hit_o and miss_o are both 0. Out of reset, no entry is valid.
- R3: Every hit sets the hit entry's reference bit to 1 at the next clock edge.
- R4: ref_clear_i clears every reference bit in one cycle. An entry hit in that same cycle keeps its bit set.
- R5: A hit with lkp_write_i high sets the entry's dirty bit. A hit with lkp_write_i low leaves the dirty bit unchanged.
- R6: A fill whose virtual page number is not already present writes into the lowest-index invalid entry, if there is one. The new entry starts with its reference bit and dirty bit both at 0.
- R7: When all entries are valid, a fill replaces the first entry whose reference bit is 0, searching upward with wrap-around from the replacement pointer. The pointer does not move in this case.
- R8: When all entries are valid and every reference bit is 1, the entry at the pointer is replaced and the pointer advances by one, wrapping at N_ENTRIES. The pointer is 0 after reset.
- R9: When a fill replaces a valid entry whose reference bit or dirty bit is set, evict_valid_o is 1 for exactly the one cycle after the fill edge. In that cycle it carries the victim's virtual page number, reference bit and dirty bit. No pulse occurs for an invalid victim, or for one with both bits at 0.
- R10: A fill whose virtual page number matches a valid entry overwrites that entry's physical page number in place. The entry keeps its status bits, and no eviction is reported.
- R11: flush_i invalidates every entry in one cycle. A fill presented in the same cycle is discarded.
- R12: inval_valid_i with inval_vpn_i invalidates only the matching entry. All other entries are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Lookup virtual page number |
| lkp_write_i | input | 1 | Lookup is a write access |
| hit_o | output | 1 | Lookup hit, combinational |
| miss_o | output | 1 | Lookup miss, combinational |
| ppn_o | output | PPN_W | Translated physical page number, 0 unless hit |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | VPN_W | Fill virtual page number |
| fill_ppn_i | input | PPN_W | Fill physical page number |
| ref_clear_i | input | 1 | Bulk clear of all reference bits |
| flush_i | input | 1 | Invalidate all entries |
| inval_valid_i | input | 1 | Single-entry invalidate request |
| inval_vpn_i | input | VPN_W | Virtual page number to invalidate |
| evict_valid_o | output | 1 | Eviction report pulse |
| evict_vpn_o | output | VPN_W | Evicted virtual page number |
| evict_ref_o | output | 1 | Evicted entry's reference bit |
| evict_dirty_o | output | 1 | Evicted entry's dirty bit |

## Verification
Reference and dirty bits cannot be read directly. A wrong status bit shows up only when the entry becomes a victim: the wrong entry is chosen, so a later lookup of that page misses or hits unexpectedly, or the eviction report carries the wrong bits one cycle after the fill. A wrong replacement pointer shows up in the same way, as the wrong page disappearing on the next fill of a full buffer. The bench therefore builds the aging sequences step by step, and after every fill it probes both the displaced page and its neighbours. A wrong valid bit or a duplicated tag appears immediately as a wrong hit, miss or physical page number on the next lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // how the fill victim was chosen
  typedef enum logic [1:0] {
    VSEL_INVALID = 2'd0,
    VSEL_CLEAR   = 2'd1,
    VSEL_POINTER = 2'd2
  } vsel_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0]       valid_i,
  input  logic [N_ENT*VPN_W-1:0] tags_i,
  input  logic [VPN_W-1:0]       key_i,
  output logic [N_ENT-1:0]       match_o,
  output logic                   hit_o,
  output logic [IDX_W-1:0]       idx_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tags_i[g*VPN_W +: VPN_W] == key_i);
  end

  assign hit_o = |match_o;

  // OR-encode: match vector is one-hot when tags are unique
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic [N_ENT-1:0] ref_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output vsel_e            sel_o
);
  logic             inv_found, clr_found;
  logic [IDX_W-1:0] inv_idx, clr_idx;
  logic [IDX_W:0]   pos;

  // lowest-index invalid entry
  always_comb begin
    inv_found = 1'b0;
    inv_idx   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        inv_found = 1'b1;
        inv_idx   = IDX_W'(i);
      end
    end
  end

  // first clear reference bit at or after the pointer, with wrap
  always_comb begin
    clr_found = 1'b0;
    clr_idx   = '0;
    pos       = '0;
    for (int k = N_ENT - 1; k >= 0; k--) begin
      pos = {1'b0, ptr_i} + (IDX_W + 1)'(k);
      if (pos >= (IDX_W + 1)'(N_ENT)) pos = pos - (IDX_W + 1)'(N_ENT);
      if (!ref_i[pos[IDX_W-1:0]]) begin
        clr_found = 1'b1;
        clr_idx   = pos[IDX_W-1:0];
      end
    end
  end

  always_comb begin
    if (inv_found) begin
      idx_o = inv_idx;
      sel_o = VSEL_INVALID;
    end else if (clr_found) begin
      idx_o = clr_idx;
      sel_o = VSEL_CLEAR;
    end else begin
      idx_o = ptr_i;
      sel_o = VSEL_POINTER;
    end
  end

  p_victim_invalid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&valid_i) |-> !valid_i[idx_o]);
  p_victim_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&valid_i) && !(&ref_i) |-> !ref_i[idx_o]);
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned VPN_W     = 20,
  parameter int unsigned PPN_W     = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  input  logic             lkp_write_i,
  output logic             hit_o,
  output logic             miss_o,
  output logic [PPN_W-1:0] ppn_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             ref_clear_i,
  input  logic             flush_i,
  input  logic             inval_valid_i,
  input  logic [VPN_W-1:0] inval_vpn_i,
  output logic             evict_valid_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_ref_o,
  output logic             evict_dirty_o
);
  localparam int unsigned IDX_W = $clog2(N_ENTRIES);

  logic [N_ENTRIES*VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0]           ppn_q [N_ENTRIES];
  logic [N_ENTRIES-1:0]       valid_q, ref_q, dirty_q;
  logic [IDX_W-1:0]           ptr_q;

  logic [N_ENTRIES-1:0] lkp_match, fill_match, inval_match;
  logic                 lkp_hit_raw, fill_hit, inval_hit;
  logic [IDX_W-1:0]     lkp_idx, fill_idx, inval_idx, vict_idx, fill_tgt;
  vsel_e                vict_sel;
  logic                 fill_we, fill_new, inval_do, evict_d;

  xlat_match #(.N_ENT(N_ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lkp_match (
    .valid_i(valid_q), .tags_i(vpn_q), .key_i(lkp_vpn_i),
    .match_o(lkp_match), .hit_o(lkp_hit_raw), .idx_o(lkp_idx)
  );

  xlat_match #(.N_ENT(N_ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
    .valid_i(valid_q), .tags_i(vpn_q), .key_i(fill_vpn_i),
    .match_o(fill_match), .hit_o(fill_hit), .idx_o(fill_idx)
  );

  xlat_match #(.N_ENT(N_ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_inval_match (
    .valid_i(valid_q), .tags_i(vpn_q), .key_i(inval_vpn_i),
    .match_o(inval_match), .hit_o(inval_hit), .idx_o(inval_idx)
  );

  xlat_victim #(.N_ENT(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .valid_i(valid_q), .ref_i(ref_q), .ptr_i(ptr_q),
    .idx_o(vict_idx), .sel_o(vict_sel)
  );

  assign hit_o  = lkp_valid_i && lkp_hit_raw;
  assign miss_o = lkp_valid_i && !lkp_hit_raw;
  assign ppn_o  = hit_o ? ppn_q[lkp_idx] : '0;

  assign fill_we  = fill_valid_i && !flush_i;
  assign fill_new = fill_we && !fill_hit;
  assign fill_tgt = fill_hit ? fill_idx : vict_idx;
  assign inval_do = inval_valid_i && inval_hit;
  assign evict_d  = fill_new && valid_q[vict_idx] && (ref_q[vict_idx] || dirty_q[vict_idx]);

  // entry storage: flush > invalidate > fill for valid; fill-new > hit > clear for ref
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ref_q   <= '0;
      dirty_q <= '0;
      vpn_q   <= '0;
      for (int i = 0; i < N_ENTRIES; i++) ppn_q[i] <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (flush_i) valid_q[i] <= 1'b0;
        else if (inval_do && inval_idx == IDX_W'(i)) valid_q[i] <= 1'b0;
        else if (fill_we && fill_tgt == IDX_W'(i)) valid_q[i] <= 1'b1;

        if (fill_we && fill_tgt == IDX_W'(i)) begin
          vpn_q[i*VPN_W +: VPN_W] <= fill_vpn_i;
          ppn_q[i]                <= fill_ppn_i;
        end

        if (fill_new && fill_tgt == IDX_W'(i)) ref_q[i] <= 1'b0;
        else if (hit_o && lkp_idx == IDX_W'(i)) ref_q[i] <= 1'b1;
        else if (ref_clear_i) ref_q[i] <= 1'b0;

        if (fill_new && fill_tgt == IDX_W'(i)) dirty_q[i] <= 1'b0;
        else if (hit_o && lkp_write_i && lkp_idx == IDX_W'(i)) dirty_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (fill_new && vict_sel == VSEL_POINTER) begin
      ptr_q <= (ptr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evict_valid_o <= 1'b0;
      evict_vpn_o   <= '0;
      evict_ref_o   <= 1'b0;
      evict_dirty_o <= 1'b0;
    end else begin
      evict_valid_o <= evict_d;
      if (evict_d) begin
        evict_vpn_o   <= vpn_q[vict_idx*VPN_W +: VPN_W];
        evict_ref_o   <= ref_q[vict_idx];
        evict_dirty_o <= dirty_q[vict_idx];
      end
    end
  end

  p_hit_xor_miss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |-> (hit_o ^ miss_o));
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !hit_o && !miss_o);
  p_no_dup_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match));
  p_ref_on_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && !(fill_new && fill_tgt == lkp_idx) |=> ref_q[$past(lkp_idx)]);
  p_ref_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_clear_i && !hit_o |=> ref_q == '0);
  p_dirty_on_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && lkp_write_i && !(fill_new && fill_tgt == lkp_idx) |=> dirty_q[$past(lkp_idx)]);
  p_evict_after_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> $past(fill_valid_i));
  p_flush_all_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> valid_q == '0);
endmodule

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 0, lkp_write = 0;
  logic [19:0] lkp_vpn = '0;
  logic        fill_valid = 0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic        ref_clear = 0, flush = 0, inval_valid = 0;
  logic [19:0] inval_vpn = '0;
  logic        hit, miss, ev_valid, ev_ref, ev_dirty;
  logic [19:0] ppn, ev_vpn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vpn_i(lkp_vpn), .lkp_write_i(lkp_write),
    .hit_o(hit), .miss_o(miss), .ppn_o(ppn),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .ref_clear_i(ref_clear), .flush_i(flush),
    .inval_valid_i(inval_valid), .inval_vpn_i(inval_vpn),
    .evict_valid_o(ev_valid), .evict_vpn_o(ev_vpn),
    .evict_ref_o(ev_ref), .evict_dirty_o(ev_dirty)
  );

  // {vpn, write, expect_hit, expect_ppn}
  localparam logic [41:0] VECS [NV] = '{
    {20'h01000, 1'b0, 1'b1, 20'h00500}, {20'h01001, 1'b0, 1'b1, 20'h00501},
    {20'h01002, 1'b0, 1'b1, 20'h00502}, {20'h01003, 1'b1, 1'b1, 20'h00503},
    {20'h01004, 1'b0, 1'b1, 20'h00504}, {20'h01005, 1'b0, 1'b1, 20'h00505},
    {20'h01006, 1'b0, 1'b1, 20'h00506}, {20'h01007, 1'b0, 1'b1, 20'h00507},
    {20'h01008, 1'b0, 1'b1, 20'h00508}, {20'h01009, 1'b0, 1'b1, 20'h00509},
    {20'h0100A, 1'b0, 1'b1, 20'h0050A}, {20'h0100B, 1'b0, 1'b1, 20'h0050B},
    {20'h0100C, 1'b0, 1'b1, 20'h0050C}, {20'h0100D, 1'b0, 1'b1, 20'h0050D},
    {20'h0100E, 1'b0, 1'b1, 20'h0050E}, {20'h0100F, 1'b0, 1'b1, 20'h0050F},
    {20'h02000, 1'b0, 1'b0, 20'h00000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] v, input bit wr, input bit eh,
                        input logic [19:0] ep, input string req);
    @(negedge clk);
    lkp_valid = 1; lkp_vpn = v; lkp_write = wr;
    #1;
    check(hit == eh, req, "hit", 32'(hit), 32'(eh));
    check(miss == !eh, req, "miss", 32'(miss), 32'(!eh));
    check(ppn == (eh ? ep : 20'h0), req, "ppn", 32'(ppn), 32'(eh ? ep : 20'h0));
    @(posedge clk); #1;
    lkp_valid = 0; lkp_write = 0;
  endtask

  // drives a fill over one edge; returns just after that edge
  task automatic fill(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk);
    fill_valid = 1; fill_vpn = v; fill_ppn = p;
    @(posedge clk); #1;
    fill_valid = 0;
  endtask

  task automatic expect_evict(input bit ev, input logic [19:0] v, input bit r,
                              input bit d, input string req);
    check(ev_valid == ev, req, "evict_valid", 32'(ev_valid), 32'(ev));
    if (ev) begin
      check(ev_vpn == v, req, "evict_vpn", 32'(ev_vpn), 32'(v));
      check(ev_ref == r, req, "evict_ref", 32'(ev_ref), 32'(r));
      check(ev_dirty == d, req, "evict_dirty", 32'(ev_dirty), 32'(d));
      @(posedge clk); #1;
      check(ev_valid == 0, req, "evict pulse width", 32'(ev_valid), 32'h0);
    end
  endtask

  initial begin
    bit any_ev;
    repeat (3) @(posedge clk);
    #1;
    // R2: reset state
    check(hit == 0 && miss == 0, "R2", "idle after reset", {30'h0, hit, miss}, 32'h0);
    check(ev_valid == 0, "R9", "no evict after reset", 32'(ev_valid), 32'h0);
    @(negedge clk); rst_n = 1;
    lookup(20'h01000, 0, 0, 20'h0, "R2");

    // R6: fill empty buffer, lowest invalid first, no eviction
    any_ev = 0;
    for (int i = 0; i < 16; i++) begin
      fill(20'h01000 + 20'(i), 20'h00500 + 20'(i));
      if (ev_valid) any_ev = 1;
    end
    check(!any_ev, "R6", "evict while filling empty slots", 32'(any_ev), 32'h0);

    // R1 R3 R5: table of lookups, all entries referenced, entry 3 written
    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i][41:22], VECS[i][21], VECS[i][20], VECS[i][19:0], "R1");
    end

    // R8: all referenced -> pointer entry 0 replaced, report ref=1 dirty=0 (R5 read hit)
    fill(20'h03000, 20'h00600);
    expect_evict(1, 20'h01000, 1, 0, "R9");
    lookup(20'h01000, 0, 0, 20'h0, "R8");
    lookup(20'h03000, 0, 1, 20'h00600, "R8");

    // R4: clear ages all; hit entry 5; fill picks entry 1 from advanced pointer
    @(negedge clk); ref_clear = 1;
    @(posedge clk); #1; ref_clear = 0;
    lookup(20'h01005, 0, 1, 20'h00505, "R3");
    fill(20'h03001, 20'h00601);
    expect_evict(0, 20'h0, 0, 0, "R4");
    lookup(20'h01001, 0, 0, 20'h0, "R4");
    lookup(20'h03000, 0, 1, 20'h00600, "R8");

    // R7: pointer did not move, entry 1 reused
    fill(20'h03002, 20'h00602);
    expect_evict(0, 20'h0, 0, 0, "R7");
    lookup(20'h03001, 0, 0, 20'h0, "R7");
    lookup(20'h01002, 0, 1, 20'h00502, "R7");

    // R12: invalidate one entry only
    @(negedge clk); inval_valid = 1; inval_vpn = 20'h03002;
    @(posedge clk); #1; inval_valid = 0;
    lookup(20'h03002, 0, 0, 20'h0, "R12");
    lookup(20'h01004, 0, 1, 20'h00504, "R12");
    fill(20'h03003, 20'h00603);
    expect_evict(0, 20'h0, 0, 0, "R6");
    lookup(20'h03003, 0, 1, 20'h00603, "R6");

    // R5: entries 1,2 referenced; entry 3 is first clear from pointer, dirty
    fill(20'h03004, 20'h00604);
    expect_evict(1, 20'h01003, 0, 1, "R5");
    lookup(20'h01003, 0, 0, 20'h0, "R5");

    // R10: fill in place
    fill(20'h01005, 20'h00777);
    expect_evict(0, 20'h0, 0, 0, "R10");
    lookup(20'h01005, 0, 1, 20'h00777, "R10");
    lookup(20'h01006, 0, 1, 20'h00506, "R10");

    // R11: flush wins over simultaneous fill
    @(negedge clk); flush = 1; fill_valid = 1; fill_vpn = 20'h04000; fill_ppn = 20'h00640;
    @(posedge clk); #1; flush = 0; fill_valid = 0;
    lookup(20'h03000, 0, 0, 20'h0, "R11");
    lookup(20'h04000, 0, 0, 20'h0, "R11");
    lookup(20'h01006, 0, 0, 20'h0, "R11");
    fill(20'h05000, 20'h00650);
    expect_evict(0, 20'h0, 0, 0, "R11");
    lookup(20'h05000, 0, 1, 20'h00650, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule